// File: doc/BRIEF.md
# Funnel Shift and Rotate Unit

This block is a single-cycle 16-bit shift and rotate engine with one private 16-bit holding register, here called the spill register. The spill register does not belong to the register file. It gives a second operand to the operations that work on a double-width value. It also keeps the bits that a rotation pushes out of the source word, so that a following operation can carry on a shift or rotate across several words. Its contents are always visible on an output port, so a move instruction can read them.

Each cycle the unit takes a source word, a 4-bit amount, a direction bit and four mode bits, and returns a result word combinationally. When the selected operation uses the spill register, the register takes its new value on the rising clock edge. The mode bits are `md_arith_i` (A), `md_rot_i` (R), `md_spill_i` (T) and `md_ext_i` (E), written below as the 4-bit pattern {A,R,T,E}. Only six patterns are legal. Any other pattern makes the unit pass the source word through and leave the spill register alone.

Top module: `funnel_shift_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `spill_o` reads 0 until an operation writes the spill register.
- R2: Pattern {A,R,T,E}=0000 is a logical shift by n=`amt_i`. With `dir_left_i`=0 it shifts right; with `dir_left_i`=1 it shifts left. Vacated bits are zero.
- R3: Pattern 1000 with `dir_left_i`=0 is an arithmetic right shift by n. Vacated upper bits copy src[15].
- R4: Pattern 0100 with `dir_left_i`=0 rotates the source word right by n.
- R5: Pattern 0010 with `dir_left_i`=0 rotates right through n bits of the spill register. The result is {S[15:16-n], src[15:n]}. S[15:16-n] is loaded with src[n-1:0]. S[15-n:0] keeps its value. With n=0 the result is src and S is unchanged.
- R6: Pattern 0010 with `dir_left_i`=1 is the mirror of R5. The result is {src[15-n:0], S[n-1:0]}. S[n-1:0] is loaded with src[15:16-n]. S[15:n] keeps its value.
- R7: Pattern 0011 rotates the 32-bit value {src,S} by n, to the right or to the left as `dir_left_i` selects. The result is the upper half of the rotated value and S is loaded with the lower half.
- R8: Pattern 0110 extracts a frame from {src,S}. To the right, the result is bits [n+15:n]. To the left, it is bits [31-n:16-n]. S is loaded with src.
- R9: Patterns 0000, 1000 and 0100 leave the spill register unchanged.
- R10: Every other pattern is illegal, and so are 1000 and 0100 with `dir_left_i`=1. An illegal pattern drives src onto `res_o` and leaves the spill register unchanged.
- R11: `res_o` follows the inputs in the same cycle with no clock edge, even while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the spill register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the spill register |
| src_i | input | 16 | Source word |
| amt_i | input | 4 | Shift or rotate amount n, 0 to 15 |
| dir_left_i | input | 1 | 1 selects left, 0 selects right |
| md_arith_i | input | 1 | Mode bit A, arithmetic |
| md_rot_i | input | 1 | Mode bit R, single-word rotate |
| md_spill_i | input | 1 | Mode bit T, use the spill register |
| md_ext_i | input | 1 | Mode bit E, double-word rotate (only with T) |
| res_o | output | 16 | Result word |
| spill_o | output | 16 | Current spill register contents |

## Verification
On every cycle the assertions check the following:
- the spill register holds its value across every operation that does not use it;
- an illegal pattern passes the source word through;
- a zero amount leaves the source word unchanged for the single-word shifts and rotates;
- the magnitude mask carries exactly n ones;
- the through-spill and double-word rotations keep the total count of ones in {result, spill}.

Only the bench's scenarios, compared against an independent bit-level model, can show the following:
- the exact bit placement in each operation;
- the sign fill of the arithmetic shift;
- the mirrored left forms;
- the frame positions;
- chains of operations that carry spill contents from one word to the next.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        OP_LSH = 3'd0,
        OP_ASR = 3'd1,
        OP_ROR = 3'd2,
        OP_RTS = 3'd3,
        OP_RDW = 3'd4,
        OP_FRM = 3'd5,
        OP_BAD = 3'd6
    } fsh_op_e;
endpackage

// File: rtl/fsh_decode.sv
module fsh_decode
    import fsh_pkg::*;
(
    input  logic    arith,
    input  logic    rot,
    input  logic    spill,
    input  logic    ext,
    input  logic    dir_left,
    output fsh_op_e op
);
    always_comb begin
        unique case ({arith, rot, spill, ext})
            4'b0000: op = OP_LSH;
            4'b1000: op = dir_left ? OP_BAD : OP_ASR;
            4'b0100: op = dir_left ? OP_BAD : OP_ROR;
            4'b0010: op = OP_RTS;
            4'b0011: op = OP_RDW;
            4'b0110: op = OP_FRM;
            default: op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/fsh_mask.sv
module fsh_mask #(
    parameter int unsigned W  = 16,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0] amt,
    input  logic          en,
    output logic [W-1:0]  hi_mask,
    output logic [W-1:0]  lo_mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hi_mask[i] = en && ((AW+1)'(W - 1 - i) < {1'b0, amt});
        assign lo_mask[i] = en && ((AW+1)'(i) < {1'b0, amt});
    end
endmodule

// File: rtl/fsh_core.sv
module fsh_core
    import fsh_pkg::*;
#(
    parameter int unsigned W  = 16,
    localparam int unsigned AW = $clog2(W),
    localparam int unsigned W2 = 2 * W
) (
    input  fsh_op_e       op,
    input  logic          dir_left,
    input  logic [AW-1:0] amt,
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  spill,
    input  logic [W-1:0]  hi_mask,
    input  logic [W-1:0]  lo_mask,
    output logic [W-1:0]  res,
    output logic [W-1:0]  spill_nxt,
    output logic          spill_we
);
    logic [W2-1:0]       pair;
    logic [W-1:0]        rot_r, rot_l, lsh, ssh;
    logic signed [W-1:0] src_s;
    logic [W2-1:0]       dw_r, dw_l;
    logic [W-1:0]        frm_r, frm_l;
    logic [W-1:0]        rts_res, rts_spill;

    assign pair  = {src, spill};
    assign src_s = src;
    assign rot_r = (src >> amt) | (src << (W - int'(amt)));
    assign rot_l = (src << amt) | (src >> (W - int'(amt)));
    assign lsh   = dir_left ? (src << amt) : (src >> amt);
    assign ssh   = src_s >>> amt;
    assign dw_r  = (pair >> amt) | (pair << (W2 - int'(amt)));
    assign dw_l  = (pair << amt) | (pair >> (W2 - int'(amt)));
    assign frm_r = pair[int'(amt) +: W];
    assign frm_l = pair[(W - int'(amt)) +: W];

    always_comb begin
        if (dir_left) begin
            rts_res   = (rot_l & ~lo_mask) | (spill & lo_mask);
            rts_spill = (rot_l & lo_mask)  | (spill & ~lo_mask);
        end else begin
            rts_res   = (rot_r & ~hi_mask) | (spill & hi_mask);
            rts_spill = (rot_r & hi_mask)  | (spill & ~hi_mask);
        end
    end

    always_comb begin
        res       = src;
        spill_nxt = spill;
        spill_we  = 1'b0;
        unique case (op)
            OP_LSH: res = lsh;
            OP_ASR: res = ssh;
            OP_ROR: res = rot_r;
            OP_RTS: begin
                res       = rts_res;
                spill_nxt = rts_spill;
                spill_we  = 1'b1;
            end
            OP_RDW: begin
                {res, spill_nxt} = dir_left ? dw_l : dw_r;
                spill_we         = 1'b1;
            end
            OP_FRM: begin
                res       = dir_left ? frm_l : frm_r;
                spill_nxt = src;
                spill_we  = 1'b1;
            end
            default: res = src;
        endcase
    end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
    import fsh_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_i,
    input  logic [AW-1:0] amt_i,
    input  logic          dir_left_i,
    input  logic          md_arith_i,
    input  logic          md_rot_i,
    input  logic          md_spill_i,
    input  logic          md_ext_i,
    output logic [W-1:0]  res_o,
    output logic [W-1:0]  spill_o
);
    typedef struct packed {
        logic [W-1:0] spill;
    } state_t;

    state_t       st_d, st_q;
    fsh_op_e      op;
    logic [W-1:0] hi_mask, lo_mask;
    logic [W-1:0] spill_nxt;
    logic         spill_we;

    fsh_decode u_dec (
        .arith    (md_arith_i),
        .rot      (md_rot_i),
        .spill    (md_spill_i),
        .ext      (md_ext_i),
        .dir_left (dir_left_i),
        .op       (op)
    );

    fsh_mask #(.W(W)) u_mask (
        .amt     (amt_i),
        .en      (op == OP_RTS),
        .hi_mask (hi_mask),
        .lo_mask (lo_mask)
    );

    fsh_core #(.W(W)) u_core (
        .op        (op),
        .dir_left  (dir_left_i),
        .amt       (amt_i),
        .src       (src_i),
        .spill     (st_q.spill),
        .hi_mask   (hi_mask),
        .lo_mask   (lo_mask),
        .res       (res_o),
        .spill_nxt (spill_nxt),
        .spill_we  (spill_we)
    );

    always_comb begin
        st_d = st_q;
        if (spill_we) st_d.spill = spill_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spill_o = st_q.spill;

    AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_LSH, OP_ASR, OP_ROR}) |=> (spill_o == $past(spill_o))); // R9
    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD) |=> (spill_o == $past(spill_o))); // R10
    AST_BAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD) |-> (res_o == src_i)); // R10
    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        ((amt_i == '0) && (op inside {OP_LSH, OP_ASR, OP_ROR})) |-> (res_o == src_i)); // R2
    AST_MASK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RTS) |-> (($countones(hi_mask) == int'(amt_i)) &&
                            ($countones(lo_mask) == int'(amt_i)))); // R5
    AST_RTS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RTS) |=> ($countones($past(src_i)) + $countones($past(spill_o)) ==
                            $countones($past(res_o)) + $countones(spill_o))); // R6
    AST_RDW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RDW) |=> ($countones($past(src_i)) + $countones($past(spill_o)) ==
                            $countones($past(res_o)) + $countones(spill_o))); // R7
endmodule

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_i = '0;
    logic [3:0]  amt_i = '0;
    logic        dir_left_i = 1'b0;
    logic        md_arith_i = 1'b0, md_rot_i = 1'b0, md_spill_i = 1'b0, md_ext_i = 1'b0;
    logic [15:0] res_o, spill_o;

    int total = 0;
    int bad = 0;
    logic [15:0] spill_model = '0;

    always #10 clk = ~clk;

    funnel_shift_unit u_funnel_shift_unit (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .amt_i(amt_i),
        .dir_left_i(dir_left_i), .md_arith_i(md_arith_i), .md_rot_i(md_rot_i),
        .md_spill_i(md_spill_i), .md_ext_i(md_ext_i), .res_o(res_o), .spill_o(spill_o)
    );

    function automatic string req_of(input logic [3:0] m, input logic l);
        case (m)
            4'b0000: return "R2";
            4'b1000: return l ? "R10" : "R3";
            4'b0100: return l ? "R10" : "R4";
            4'b0010: return l ? "R6" : "R5";
            4'b0011: return "R7";
            4'b0110: return "R8";
            default: return "R10";
        endcase
    endfunction

    // returns {result, next spill}
    function automatic logic [31:0] model(input logic [3:0] m, input logic l,
                                          input int n, input logic [15:0] s,
                                          input logic [15:0] t);
        logic [15:0] r, tn;
        logic [31:0] p, q;
        p = {s, t};
        r = s;
        tn = t;
        case (m)
            4'b0000: for (int i = 0; i < 16; i++)
                r[i] = l ? ((i >= n) ? s[i-n] : 1'b0) : ((i + n < 16) ? s[i+n] : 1'b0);
            4'b1000: if (!l) for (int i = 0; i < 16; i++)
                r[i] = (i + n < 16) ? s[i+n] : s[15];
            4'b0100: if (!l) for (int i = 0; i < 16; i++)
                r[i] = s[(i + n) % 16];
            4'b0010: for (int i = 0; i < 16; i++) begin
                if (!l) begin
                    r[i]  = (i < 16 - n) ? s[i+n] : t[i];
                    tn[i] = (i >= 16 - n) ? s[i-(16-n)] : t[i];
                end else begin
                    r[i]  = (i >= n) ? s[i-n] : t[i];
                    tn[i] = (i < n) ? s[16-n+i] : t[i];
                end
            end
            4'b0011: begin
                for (int i = 0; i < 32; i++)
                    q[i] = l ? p[(i - n + 32) % 32] : p[(i + n) % 32];
                r = q[31:16];
                tn = q[15:0];
            end
            4'b0110: begin
                for (int i = 0; i < 16; i++)
                    r[i] = l ? p[16 + i - n] : p[i + n];
                tn = s;
            end
            default: ;
        endcase
        return {r, tn};
    endfunction

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic l, input int n,
                          input logic [15:0] s);
        logic [31:0] e;
        @(negedge clk);
        {md_arith_i, md_rot_i, md_spill_i, md_ext_i} = m;
        dir_left_i = l;
        amt_i = 4'(n);
        src_i = s;
        e = model(m, l, n, s, spill_model);
        #2;
        chk(req_of(m, l), res_o, e[31:16], "result");
        @(posedge clk);
        #2;
        spill_model = e[15:0];
        chk(req_of(m, l), spill_o, spill_model, "spill");
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] legal [6];
        void'($urandom(32'd4711));
        legal = '{4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0011, 4'b0110};
        // R11: comb result under reset
        src_i = 16'h8421; amt_i = 4'd4; dir_left_i = 1'b1;
        #5;
        chk("R11", res_o, 16'h4210, "comb during reset");
        chk("R1", spill_o, 16'h0000, "reset spill");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", spill_o, 16'h0000, "spill after release");
        // directed corner cases
        run_op(4'b1000, 1'b0, 15, 16'h8000);  // R3 sign fill
        run_op(4'b1000, 1'b0, 3, 16'h9F00);   // R3
        run_op(4'b0100, 1'b0, 4, 16'h1234);   // R4
        run_op(4'b0011, 1'b0, 8, 16'hABCD);   // R7 load spill
        run_op(4'b0010, 1'b0, 0, 16'h5555);   // R5 n=0
        run_op(4'b0010, 1'b0, 15, 16'hFFFF);  // R5 max mask
        run_op(4'b0010, 1'b1, 5, 16'h0F0F);   // R6
        run_op(4'b0011, 1'b1, 15, 16'h8001);  // R7 left
        run_op(4'b0110, 1'b0, 0, 16'hC3C3);   // R8 right n=0 -> spill
        run_op(4'b0110, 1'b1, 0, 16'h1111);   // R8 left n=0 -> src
        run_op(4'b0110, 1'b0, 7, 16'h2468);   // R8
        run_op(4'b0000, 1'b0, 0, 16'hBEEF);   // R2 zero amount, R9
        run_op(4'b0000, 1'b1, 15, 16'hFFFF);  // R2
        run_op(4'b1000, 1'b1, 2, 16'h7777);   // R10 left arith
        run_op(4'b0100, 1'b1, 2, 16'h7777);   // R10 left rotate
        run_op(4'b1111, 1'b0, 9, 16'h3C3C);   // R10
        run_op(4'b0001, 1'b1, 9, 16'h3C3C);   // R10
        // constrained random: mostly legal patterns
        for (int k = 0; k < 600; k++) begin
            logic [3:0] m;
            if ($urandom % 8 == 0) m = 4'($urandom);
            else m = legal[$urandom % 6];
            run_op(m, 1'($urandom), int'($urandom % 16), 16'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule